// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This block joins two 8-input interrupt controllers into one system with 15 usable sources. The upper controller (the master) drives the CPU interrupt line. The lower controller (the slave) feeds its requests in through master input 2. Each controller keeps a request register, an in-service register and a trigger-mode register, and picks a winner with fixed priority: the lowest index wins. A request wins only if it has higher priority than everything currently in service.

When the CPU pulses the acknowledge strobe, the unit picks the master's winner and moves it to in-service. If that winner is the cascade input, the unit also acknowledges the slave. On the next cycle it presents the 8-bit vector and the global line number, with a one-cycle valid flag. If nothing is eligible at acknowledge, the unit reports line 7 of the controller concerned. Vector bases come from outside. An end-of-service strobe that names a global line clears that line's in-service bit.

Top module: `dual_pic_ack`

## Requirements
- R1: After reset, `cpu_irq` and `ack_valid` are 0, and both trigger-mode readbacks are 0.
- R2: Global lines 0–7 belong to the master and 8–15 to the slave. Bit 3 of a line number selects the controller and bits 2:0 select the input, both for `ack_line` and for `eoi_line`.
- R3: On an edge-mode input, a low-to-high transition latches a request. After that request is acknowledged, a level that stays high raises no new request.
- R4: On a level-mode input, the request follows the input level. Acknowledge does not clear it, and dropping the input withdraws it on the next clock.
- R5: The lowest pending index wins. An in-service line blocks requests of equal or lower priority, while a higher-priority request still interrupts (nesting).
- R6: `cpu_irq` is 1 exactly when the master has an eligible request. A winning slave request sets master input 2 as an edge one clock later. The external `irq_in[2]` has no effect.
- R7: When `ack` is high for one clock with a master winner other than 2, that line becomes in service. One clock later `ack_valid` is 1 for a single cycle, `ack_vector` = {m_base[7:3], line} and `ack_line` = line.
- R8: When the master winner at `ack` is input 2, the slave winner s is also placed in service. Then `ack_vector` = {s_base[7:3], s} and `ack_line` = 8 + s.
- R9: With no master winner at `ack`, the unit reports line 7 with vector {m_base[7:3], 3'd7}, and no in-service bit changes.
- R10: When master input 2 is acknowledged but the slave has no winner, the unit reports line 15 with vector {s_base[7:3], 3'd7}.
- R11: A trigger-mode write (`tm_sel` 0 = master, 1 = slave; a 1 bit means level mode) stores the data ANDed with 0xF8 for the master and 0xDE for the slave.
- R12: When `eoi` is high for one clock, the in-service bit of `eoi_line` is cleared, and lower-priority requests become eligible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request lines; 8–15 go to the slave, bit 2 is unused |
| ack | input | 1 | Single-cycle acknowledge strobe |
| eoi | input | 1 | Single-cycle end-of-service strobe |
| eoi_line | input | 4 | Global line whose in-service bit is cleared |
| tm_we | input | 1 | Trigger-mode write enable |
| tm_sel | input | 1 | Trigger-mode target: 0 master, 1 slave |
| tm_wdata | input | 8 | Trigger-mode write data |
| m_base | input | 8 | Master vector base; bits 2:0 ignored |
| s_base | input | 8 | Slave vector base; bits 2:0 ignored |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| ack_valid | output | 1 | Vector and line valid, one cycle after `ack` |
| ack_vector | output | 8 | Acknowledged vector |
| ack_line | output | 4 | Acknowledged global line |
| tm_master | output | 8 | Master trigger-mode readback |
| tm_slave | output | 8 | Slave trigger-mode readback |

## Verification
The bench goes after the cascade path, where a slave request must show up as master input 2 and a single strobe must acknowledge both controllers. A design that failed to suppress the cascade feed during the acknowledge cycle would raise a second, phantom interrupt. The two spurious fallbacks are checked at the ports: a master spurious acknowledge that wrongly set in-service bit 7 would then hide a genuine line 7 request. The bench also drives a level-mode slave request that drops before acknowledge, which must produce line 15. Nesting and end-of-service order are exercised, along with masked trigger-mode writes and a vector base with nonzero low bits. A design that leaked the low bits of the base into the vector would fail those checks.

// File: rtl/dual_pic_ack.sv
module dual_pic_ack #(
  parameter logic [7:0] M_TM_MASK = 8'hF8,
  parameter logic [7:0] S_TM_MASK = 8'hDE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_in,
  input  logic        ack,
  input  logic        eoi,
  input  logic [3:0]  eoi_line,
  input  logic        tm_we,
  input  logic        tm_sel,
  input  logic [7:0]  tm_wdata,
  input  logic [7:0]  m_base,
  input  logic [7:0]  s_base,
  output logic        cpu_irq,
  output logic        ack_valid,
  output logic [7:0]  ack_vector,
  output logic [3:0]  ack_line,
  output logic [7:0]  tm_master,
  output logic [7:0]  tm_slave
);

  function automatic logic [3:0] first_set(input logic [7:0] v);
    first_set = 4'd8;
    for (int i = 7; i >= 0; i--)
      if (v[i]) first_set = 4'(i);
  endfunction

  logic [7:0] irr_m, irr_s, isr_m, isr_s, last_m, last_s, tm_m, tm_s;

  wire [3:0] m_req = first_set(irr_m);
  wire [3:0] m_cur = first_set(isr_m);
  wire [3:0] s_req = first_set(irr_s);
  wire [3:0] s_cur = first_set(isr_s);
  wire       m_win = m_req < m_cur;
  wire       s_win = s_req < s_cur;

  wire [7:0] lvl_m = {irq_in[7:3], 1'b0, irq_in[1:0]};
  wire [7:0] lvl_s = irq_in[15:8];
  wire       casc  = s_win & ~ack;

  wire [7:0] edge_m = (lvl_m & ~last_m) | {5'b0, casc, 2'b0};
  wire [7:0] edge_s = lvl_s & ~last_s;

  wire       to_slave  = ack & m_win & (m_req[2:0] == 3'd2);
  wire [7:0] ack_m_bit = (ack & m_win) ? (8'd1 << m_req[2:0]) : 8'd0;
  wire [7:0] ack_s_bit = (to_slave & s_win) ? (8'd1 << s_req[2:0]) : 8'd0;
  wire [7:0] eoi_m = (eoi & ~eoi_line[3]) ? (8'd1 << eoi_line[2:0]) : 8'd0;
  wire [7:0] eoi_s = (eoi &  eoi_line[3]) ? (8'd1 << eoi_line[2:0]) : 8'd0;
  wire [2:0] s_pick = s_win ? s_req[2:0] : 3'd7;

  assign cpu_irq   = m_win;
  assign tm_master = tm_m;
  assign tm_slave  = tm_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_m <= '0; irr_s <= '0; isr_m <= '0; isr_s <= '0;
      last_m <= '0; last_s <= '0; tm_m <= '0; tm_s <= '0;
      ack_valid <= 1'b0; ack_vector <= '0; ack_line <= '0;
    end else begin
      irr_m  <= (tm_m & lvl_m) | (~tm_m & ((irr_m & ~ack_m_bit) | edge_m));
      irr_s  <= (tm_s & lvl_s) | (~tm_s & ((irr_s & ~ack_s_bit) | edge_s));
      isr_m  <= (isr_m & ~eoi_m) | ack_m_bit;
      isr_s  <= (isr_s & ~eoi_s) | ack_s_bit;
      last_m <= lvl_m;
      last_s <= lvl_s;
      if (tm_we && !tm_sel) tm_m <= tm_wdata & M_TM_MASK;
      if (tm_we &&  tm_sel) tm_s <= tm_wdata & S_TM_MASK;
      ack_valid <= ack;
      if (ack) begin
        if (!m_win) begin
          ack_line   <= 4'd7;
          ack_vector <= {m_base[7:3], 3'd7};
        end else if (to_slave) begin
          ack_line   <= {1'b1, s_pick};
          ack_vector <= {s_base[7:3], s_pick};
        end else begin
          ack_line   <= {1'b0, m_req[2:0]};
          ack_vector <= {m_base[7:3], m_req[2:0]};
        end
      end
    end
  end

  p_ack_sets_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && cpu_irq) |=> (isr_m != 8'd0));

  p_spurious_keeps_service_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !cpu_irq) |=> ($stable(isr_m) || $past(eoi)));

  p_master_vector_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_line[3]) |-> (ack_vector[7:3] == $past(m_base[7:3])));

  p_slave_vector_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_line[3]) |-> (ack_vector[7:3] == $past(s_base[7:3])));

  p_eoi_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && !eoi_line[3]) |=> !isr_m[$past(eoi_line[2:0])]);

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !$past(ack)) |-> 1'b0);

endmodule

// File: tb/dual_pic_ack_test.sv
module dual_pic_ack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic        ack = 1'b0, eoi = 1'b0, tm_we = 1'b0, tm_sel = 1'b0;
  logic [3:0]  eoi_line = '0;
  logic [7:0]  tm_wdata = '0;
  logic [7:0]  m_base = 8'h23, s_base = 8'h75;
  logic        cpu_irq, ack_valid;
  logic [7:0]  ack_vector, tm_master, tm_slave;
  logic [3:0]  ack_line;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_pic_ack uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack(ack), .eoi(eoi),
    .eoi_line(eoi_line), .tm_we(tm_we), .tm_sel(tm_sel), .tm_wdata(tm_wdata),
    .m_base(m_base), .s_base(s_base), .cpu_irq(cpu_irq), .ack_valid(ack_valid),
    .ack_vector(ack_vector), .ack_line(ack_line), .tm_master(tm_master),
    .tm_slave(tm_slave));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_ack(input string req, input int vec, input int line);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check({req, " valid"}, ack_valid, 1);
    check({req, " vector"}, ack_vector, vec);
    check({req, " line"}, ack_line, line);
    @(negedge clk);
    check({req, " valid single"}, ack_valid, 0);
  endtask

  task automatic do_eoi(input int line);
    @(negedge clk); eoi = 1'b1; eoi_line = 4'(line);
    @(negedge clk); eoi = 1'b0;
  endtask

  task automatic write_tm(input bit sel, input logic [7:0] d);
    @(negedge clk); tm_we = 1'b1; tm_sel = sel; tm_wdata = d;
    @(negedge clk); tm_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 cpu_irq", cpu_irq, 0);
    check("R1 ack_valid", ack_valid, 0);
    check("R1 tm_master", tm_master, 0);
    check("R1 tm_slave", tm_slave, 0);
  endtask

  task automatic t_trigger_masks;
    write_tm(1'b0, 8'hFF);
    check("R11 master mask", tm_master, 8'hF8);
    write_tm(1'b1, 8'hFF);
    check("R11 slave mask", tm_slave, 8'hDE);
    check("R11 master untouched", tm_master, 8'hF8);
    write_tm(1'b0, 8'h00);
    write_tm(1'b1, 8'h00);
    check("R11 cleared", tm_slave, 0);
  endtask

  task automatic t_edge;
    @(negedge clk); irq_in[5] = 1'b1;
    wait_cyc(1);
    check("R6 irq raised", cpu_irq, 1);
    do_ack("R7 master line 5", 8'h25, 5);
    check("R3 irq cleared after ack", cpu_irq, 0);
    do_eoi(5);
    wait_cyc(2);
    check("R3 held level no re-request", cpu_irq, 0);
    irq_in[5] = 1'b0;
    wait_cyc(1);
  endtask

  task automatic t_nesting;
    @(negedge clk); irq_in[6] = 1'b1; irq_in[4] = 1'b1;
    wait_cyc(1);
    do_ack("R5 lowest index wins", 8'h24, 4);
    check("R5 line 6 blocked", cpu_irq, 0);
    irq_in[1] = 1'b1;
    wait_cyc(1);
    check("R5 higher nests", cpu_irq, 1);
    do_ack("R5 nested ack", 8'h21, 1);
    do_eoi(1);
    check("R12 still blocked by 4", cpu_irq, 0);
    do_eoi(4);
    check("R12 line 6 eligible", cpu_irq, 1);
    do_ack("R12 line 6 ack", 8'h26, 6);
    do_eoi(6);
    irq_in = '0;
    wait_cyc(1);
    check("R12 idle", cpu_irq, 0);
  endtask

  task automatic t_cascade;
    @(negedge clk); irq_in[2] = 1'b1;
    wait_cyc(3);
    check("R6 irq_in[2] ignored", cpu_irq, 0);
    irq_in[2] = 1'b0;
    irq_in[13] = 1'b1;
    wait_cyc(1);
    check("R6 cascade one clock later", cpu_irq, 0);
    wait_cyc(1);
    check("R6 cascade raises irq", cpu_irq, 1);
    do_ack("R8 R2 slave line 13", 8'h75, 13);
    wait_cyc(2);
    check("R8 no phantom request", cpu_irq, 0);
    do_eoi(13);
    do_eoi(2);
    wait_cyc(2);
    check("R3 slave edge no re-request", cpu_irq, 0);
    irq_in[13] = 1'b0;
    wait_cyc(1);
  endtask

  task automatic t_level_and_slave_spurious;
    write_tm(1'b1, 8'h08);
    @(negedge clk); irq_in[11] = 1'b1;
    wait_cyc(2);
    check("R4 slave level request", cpu_irq, 1);
    do_ack("R8 level slave 11", 8'h73, 11);
    do_eoi(11);
    do_eoi(2);
    wait_cyc(2);
    check("R4 level survives ack", cpu_irq, 1);
    irq_in[11] = 1'b0;
    wait_cyc(2);
    do_ack("R10 slave spurious", 8'h77, 15);
    do_eoi(2);
    wait_cyc(2);
    check("R10 idle after spurious", cpu_irq, 0);
    write_tm(1'b1, 8'h00);
    write_tm(1'b0, 8'h10);
    @(negedge clk); irq_in[4] = 1'b1;
    wait_cyc(1);
    check("R4 master level request", cpu_irq, 1);
    irq_in[4] = 1'b0;
    wait_cyc(1);
    check("R4 level withdrawn", cpu_irq, 0);
    write_tm(1'b0, 8'h00);
  endtask

  task automatic t_master_spurious;
    do_ack("R9 master spurious", 8'h27, 7);
    @(negedge clk); irq_in[7] = 1'b1;
    wait_cyc(1);
    check("R9 no in-service change", cpu_irq, 1);
    do_ack("R9 genuine line 7", 8'h27, 7);
    do_eoi(7);
    irq_in[7] = 1'b0;
    wait_cyc(1);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_trigger_masks();
    t_edge();
    t_nesting();
    t_cascade();
    t_level_and_slave_spurious();
    t_master_spurious();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule